// File: doc/BRIEF.md
# Segmented Current-Steering DAC Switch Decoder

This block takes a 10-bit straight-binary sample and turns it into the switch drives of a segmented current-steering converter. The sample is split three ways. The upper five bits pick how many of 31 equal coarse segments steer their current to output A. The next four bits pick how many of 15 equal fine segments do the same, where each fine segment carries one sixteenth of a coarse segment. The lowest bit steers a single switch that carries half of one fine segment. Every switch has its own pair of drives, one toward output A and one toward output B. The pair is registered together, so each switch changes state on a single clock edge and current is never steered to both outputs or to neither.

Samples arrive on a valid/ready port. The block takes one sample per clock and has no internal back-pressure. It deasserts `in_ready` only while reset or sleep is asserted. A sample is accepted on a rising edge where `in_valid` and `in_ready` are both high. A sample offered while `in_ready` is low is not taken, and the producer must hold it or drop it. While sleep is asserted, the block parks every switch so that all current flows to output B. The last accepted code is kept for the time sleep lasts. A weighted-sum monitor rebuilds the code from the registered drives so that the decoding can be checked digitally.

Top module: `seg_dac_decoder`

## Requirements
- R1: While `rst` is high on a rising edge, the input register clears to code 0. After that edge every A drive is 0, every B drive is 1, `mon_a` is 0, `mon_b` is 1023 and `in_ready` is 0.
- R2: Bit i of `coarse_a` is 1 exactly when i is less than code[9:5]. The coarse drives therefore form a thermometer whose length is the value of the five upper bits.
- R3: Bit j of `fine_a` is 1 exactly when j is less than code[4:1]. The fine drives form a thermometer whose length is the value of bits 4 to 1.
- R4: `lsb_a` equals code[0].
- R5: Each B drive is always the complement of its A drive (`coarse_b == ~coarse_a`, `fine_b == ~fine_a`, `lsb_b == ~lsb_a`).
- R6: A sample accepted on edge k appears on the drives after edge k+1, provided sleep is low on edge k+1. Samples may be accepted on back-to-back edges, one per clock.
- R7: On edges where `in_valid` is low, the input register holds its code and the drives stay unchanged.
- R8: `in_ready` is low while `sleep` or `rst` is high. A rising edge with `sleep` high forces every A drive to 0 and every B drive to 1. A sample offered during sleep is not accepted.
- R9: After sleep is released, the first edge restores the drives for the last code accepted before sleep.
- R10: `mon_a` equals 32×(coarse A count) + 2×(fine A count) + `lsb_a`, which is the registered code. `mon_b` is built with the same weights from the B drives and equals 1023 minus that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Park all current on output B and stop accepting samples |
| in_valid | input | 1 | Sample on `in_code` is valid |
| in_ready | output | 1 | Block accepts a sample on this edge |
| in_code | input | 10 | Straight-binary sample, 0 to 1023 |
| coarse_a | output | 31 | Coarse segment drives toward output A |
| coarse_b | output | 31 | Coarse segment drives toward output B |
| fine_a | output | 15 | Fine segment drives toward output A |
| fine_b | output | 15 | Fine segment drives toward output B |
| lsb_a | output | 1 | Binary LSB switch drive toward output A |
| lsb_b | output | 1 | Binary LSB switch drive toward output B |
| mon_a | output | 10 | Weighted sum of the A drives in LSB units |
| mon_b | output | 10 | Weighted sum of the B drives in LSB units |

## Verification
The bench builds the block with its default split of five coarse bits, four fine bits and one binary bit. With that split, every one of the 1024 input codes can be driven back to back in a single exhaustive sweep. The sweep passes every length of both thermometers, including the empty and the full cases. It also passes every carry boundary between the fine and coarse fields, such as 31 to 32 and 511 to 512. Directed sequences then cover idle cycles, sleep entry and exit with a sample offered during sleep, and a reset applied while the drives are active.

// File: rtl/dac_seg_pkg.sv
package dac_seg_pkg;

  typedef enum logic {
    DRV_DECODE = 1'b0,
    DRV_IDLE   = 1'b1
  } drv_mode_e;

  localparam int unsigned CNT_W = 64;

  function automatic int unsigned count_ones(input logic [CNT_W-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < CNT_W; i++) begin
      n += 32'(v[i]);
    end
    return n;
  endfunction

endpackage

// File: rtl/dac_in_reg.sv
module dac_in_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sleep,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_code,
  output logic [W-1:0] code_q
);

  assign in_ready = !rst && !sleep;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
    end else if (in_valid && in_ready) begin
      code_q <= in_code;
    end
  end

endmodule

// File: rtl/dac_thermo.sv
module dac_thermo #(
  parameter int IN_W  = 5,
  localparam int OUT_N = (2 ** IN_W) - 1
) (
  input  logic [IN_W-1:0]  val,
  output logic [OUT_N-1:0] therm
);

  for (genvar i = 0; i < OUT_N; i++) begin : g_seg
    assign therm[i] = (val > IN_W'(i));
  end

endmodule

// File: rtl/dac_drive_stage.sv
module dac_drive_stage
  import dac_seg_pkg::*;
#(
  parameter int N = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  drv_mode_e    mode,
  input  logic [N-1:0] dec,
  output logic [N-1:0] drv_a,
  output logic [N-1:0] drv_b
);

  for (genvar i = 0; i < N; i++) begin : g_sw
    always_ff @(posedge clk) begin
      if (rst || mode == DRV_IDLE) begin
        drv_a[i] <= 1'b0;
        drv_b[i] <= 1'b1;
      end else begin
        drv_a[i] <= dec[i];
        drv_b[i] <= !dec[i];
      end
    end
  end

endmodule

// File: rtl/dac_weight_mon.sv
module dac_weight_mon
  import dac_seg_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int COARSE_N  = 31,
  parameter int FINE_N    = 15,
  parameter int COARSE_WT = 32,
  parameter int FINE_WT   = 2
) (
  input  logic [COARSE_N-1:0] coarse,
  input  logic [FINE_N-1:0]   fine,
  input  logic                lsb,
  output logic [DATA_W-1:0]   sum
);

  int unsigned n_coarse;
  int unsigned n_fine;

  always_comb begin
    n_coarse = count_ones(CNT_W'(coarse));
    n_fine   = count_ones(CNT_W'(fine));
    sum = DATA_W'(COARSE_WT * n_coarse + FINE_WT * n_fine + 32'(lsb));
  end

endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
  import dac_seg_pkg::*;
#(
  parameter int COARSE_BITS = 5,
  parameter int FINE_BITS   = 4,
  localparam int DATA_W    = COARSE_BITS + FINE_BITS + 1,
  localparam int COARSE_N  = (2 ** COARSE_BITS) - 1,
  localparam int FINE_N    = (2 ** FINE_BITS) - 1,
  localparam int COARSE_WT = 2 ** (FINE_BITS + 1),
  localparam int FINE_WT   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sleep,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_code,
  output logic [COARSE_N-1:0] coarse_a,
  output logic [COARSE_N-1:0] coarse_b,
  output logic [FINE_N-1:0]   fine_a,
  output logic [FINE_N-1:0]   fine_b,
  output logic                lsb_a,
  output logic                lsb_b,
  output logic [DATA_W-1:0]   mon_a,
  output logic [DATA_W-1:0]   mon_b
);

  logic [DATA_W-1:0]   code_q;
  logic [COARSE_N-1:0] coarse_dec;
  logic [FINE_N-1:0]   fine_dec;
  drv_mode_e           mode;

  assign mode = sleep ? DRV_IDLE : DRV_DECODE;

  dac_in_reg #(.W(DATA_W)) i_in_reg (
    .clk      (clk),
    .rst      (rst),
    .sleep    (sleep),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_code  (in_code),
    .code_q   (code_q)
  );

  dac_thermo #(.IN_W(COARSE_BITS)) i_coarse_dec (
    .val   (code_q[DATA_W-1 -: COARSE_BITS]),
    .therm (coarse_dec)
  );

  dac_thermo #(.IN_W(FINE_BITS)) i_fine_dec (
    .val   (code_q[FINE_BITS:1]),
    .therm (fine_dec)
  );

  dac_drive_stage #(.N(COARSE_N)) i_coarse_drv (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .dec   (coarse_dec),
    .drv_a (coarse_a),
    .drv_b (coarse_b)
  );

  dac_drive_stage #(.N(FINE_N)) i_fine_drv (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .dec   (fine_dec),
    .drv_a (fine_a),
    .drv_b (fine_b)
  );

  dac_drive_stage #(.N(1)) i_lsb_drv (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .dec   (code_q[0]),
    .drv_a (lsb_a),
    .drv_b (lsb_b)
  );

  dac_weight_mon #(
    .DATA_W(DATA_W), .COARSE_N(COARSE_N), .FINE_N(FINE_N),
    .COARSE_WT(COARSE_WT), .FINE_WT(FINE_WT)
  ) i_mon_a (
    .coarse (coarse_a),
    .fine   (fine_a),
    .lsb    (lsb_a),
    .sum    (mon_a)
  );

  dac_weight_mon #(
    .DATA_W(DATA_W), .COARSE_N(COARSE_N), .FINE_N(FINE_N),
    .COARSE_WT(COARSE_WT), .FINE_WT(FINE_WT)
  ) i_mon_b (
    .coarse (coarse_b),
    .fine   (fine_b),
    .lsb    (lsb_b),
    .sum    (mon_b)
  );

endmodule

// File: rtl/seg_dac_decoder_chk.sv
module seg_dac_decoder_chk #(
  parameter int DATA_W   = 10,
  parameter int COARSE_N = 31,
  parameter int FINE_N   = 15
) (
  input logic                clk,
  input logic                rst,
  input logic                sleep,
  input logic                in_valid,
  input logic                in_ready,
  input logic [DATA_W-1:0]   in_code,
  input logic [COARSE_N-1:0] coarse_a,
  input logic [COARSE_N-1:0] coarse_b,
  input logic [FINE_N-1:0]   fine_a,
  input logic [FINE_N-1:0]   fine_b,
  input logic                lsb_a,
  input logic                lsb_b,
  input logic [DATA_W-1:0]   mon_a,
  input logic [DATA_W-1:0]   mon_b
);

  localparam logic [DATA_W-1:0] FULL = '1;

  AST_RESET_PARK: assert property (@(posedge clk)
    rst |=> (coarse_a == '0 && fine_a == '0 && !lsb_a && mon_b == FULL)); // R1

  AST_COARSE_THERMO: assert property (@(posedge clk) disable iff (rst)
    ((coarse_a & (coarse_a + 1'b1)) == '0)); // R2

  AST_FINE_THERMO: assert property (@(posedge clk) disable iff (rst)
    ((fine_a & (fine_a + 1'b1)) == '0)); // R3

  AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    (coarse_b == ~coarse_a && fine_b == ~fine_a && lsb_b == !lsb_a)); // R5

  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) ##1 !sleep |=> (mon_a == $past(in_code, 2))); // R6

  AST_SLEEP_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !in_ready); // R8

  AST_SLEEP_PARK: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (coarse_a == '0 && fine_a == '0 && !lsb_a)); // R8

  AST_MONITOR_BALANCE: assert property (@(posedge clk) disable iff (rst)
    (DATA_W'(mon_a + mon_b) == FULL)); // R10

endmodule

bind seg_dac_decoder seg_dac_decoder_chk #(
  .DATA_W(DATA_W), .COARSE_N(COARSE_N), .FINE_N(FINE_N)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .sleep    (sleep),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_code  (in_code),
  .coarse_a (coarse_a),
  .coarse_b (coarse_b),
  .fine_a   (fine_a),
  .fine_b   (fine_b),
  .lsb_a    (lsb_a),
  .lsb_b    (lsb_b),
  .mon_a    (mon_a),
  .mon_b    (mon_b)
);

// File: tb/test_seg_dac_decoder.sv
module test_seg_dac_decoder;

  localparam int CLK_PERIOD = 8;
  localparam int DATA_W     = 10;
  localparam int COARSE_N   = 31;
  localparam int FINE_N     = 15;
  localparam int FULL       = 1023;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                sleep = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [DATA_W-1:0]   in_code = '0;
  logic [COARSE_N-1:0] coarse_a, coarse_b;
  logic [FINE_N-1:0]   fine_a, fine_b;
  logic                lsb_a, lsb_b;
  logic [DATA_W-1:0]   mon_a, mon_b;

  seg_dac_decoder i_seg_dac_decoder (
    .clk(clk), .rst(rst), .sleep(sleep), .in_valid(in_valid),
    .in_ready(in_ready), .in_code(in_code),
    .coarse_a(coarse_a), .coarse_b(coarse_b),
    .fine_a(fine_a), .fine_b(fine_b),
    .lsb_a(lsb_a), .lsb_b(lsb_b),
    .mon_a(mon_a), .mon_b(mon_b)
  );

  always #(CLK_PERIOD / 2) clk = !clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int due;
    int code;
  } exp_t;
  exp_t exp_q[$];

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint thermo(input int n);
    return (longint'(1) << n) - 1;
  endfunction

  task automatic check_code(input int code);
    int c_len = code >> 5;
    int f_len = (code >> 1) & 15;
    check(coarse_a == COARSE_N'(thermo(c_len)), "R2 coarse thermometer", coarse_a, thermo(c_len));
    check(fine_a == FINE_N'(thermo(f_len)), "R3 fine thermometer", fine_a, thermo(f_len));
    check(lsb_a == code[0], "R4 lsb drive", lsb_a, code & 1);
    check(coarse_b == ~coarse_a && fine_b == ~fine_a && lsb_b == !lsb_a,
          "R5 complement pairs", {coarse_b, fine_b, lsb_b}, {~coarse_a, ~fine_a, !lsb_a});
    check(mon_a == DATA_W'(code), "R10 monitor A / R6 latency", mon_a, code);
    check(mon_b == DATA_W'(FULL - code), "R10 monitor B", mon_b, FULL - code);
  endtask

  task automatic check_parked(input string req);
    check(coarse_a == '0 && fine_a == '0 && !lsb_a, req, {coarse_a, fine_a, lsb_a}, 0);
    check(coarse_b == '1 && fine_b == '1 && lsb_b, req, {coarse_b, fine_b, lsb_b}, {1'b0, {(COARSE_N+FINE_N+1){1'b1}}});
    check(mon_a == '0 && mon_b == DATA_W'(FULL), req, mon_b, FULL);
  endtask

  // Monitor: compare expected items in the cycle they become due
  always @(negedge clk) begin
    if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      check_code(e.code);
    end
  end

  // Driver: offer one sample, expected two edges later
  task automatic send(input int code);
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = DATA_W'(code);
    exp_q.push_back('{due: cyc + 2, code: code});
  endtask

  task automatic go_idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check_parked("R1 reset park");
    check(!in_ready, "R1 ready low in reset", in_ready, 0);
    rst = 1'b0;
    #1;
    check(in_ready, "R8 ready high when awake", in_ready, 1);

    // R2 R3 R4 R5 R6 R10: exhaustive back-to-back sweep
    for (int c = 0; c <= FULL; c++) send(c);
    @(negedge clk);
    in_valid = 1'b0;
    in_code  = DATA_W'(5);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R6 all sweep items delivered", exp_q.size(), 0);

    // R7: hold with in_valid low
    for (int k = 0; k < 4; k++) begin
      check(mon_a == DATA_W'(FULL) && coarse_a == '1, "R7 hold without valid", mon_a, FULL);
      @(negedge clk);
    end

    // Descending pattern with gaps
    send(512); go_idle(3);
    send(511); go_idle(3);
    send(32);  send(31); go_idle(3);

    // R8 R9: sleep entry, offered sample, release
    send(300); go_idle(3);
    sleep    = 1'b1;
    in_valid = 1'b1;
    in_code  = DATA_W'(700);
    #1;
    check(!in_ready, "R8 ready low in sleep", in_ready, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_parked("R8 sleep park");
    end
    sleep    = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check(mon_a == DATA_W'(300), "R9 restore held code / R8 sample ignored", mon_a, 300);
    check_code(300);
    send(700); go_idle(3);

    // R1: reset while active
    send(999); go_idle(3);
    rst = 1'b1;
    @(negedge clk);
    check_parked("R1 reset while active");
    rst = 1'b0;
    @(negedge clk);
    check_parked("R1 cleared code stays zero");

    go_idle(2);
    finish_run();
  end

endmodule